// File: doc/BRIEF.md
# FSK Tone Generator with Pulse-Density Output

This block turns a serial data bit into a frequency-shift-keyed audio tone and drives that tone out as a single-bit pulse-density stream. A fixed divider of the system clock produces a sample strobe. On each strobe a 16-bit phase accumulator adds a frequency word. Each time the accumulator carries out, a two-register recursive oscillator takes one step. The oscillator holds an 8-bit position and an 8-bit velocity, and together they trace an approximate sine. A two-bit channel-plan select and the data bit pick the frequency word.

The position is a signed value. It is moved to an unsigned mid-scale level and fed to a first-order accumulator modulator, whose carry is the output pin. An external low-pass filter recovers the analog tone. A tone-enable input parks the output at mid-scale and freezes the oscillator. Changing the data bit never restarts the oscillator, so the phase stays continuous across bit boundaries.

Top module: `fsk_pdm_gen`

## Requirements
- R1: The sample strobe occurs once every STROBE_DIV clock cycles. The first strobe edge is the STROBE_DIV-th rising edge after reset is released. The oscillator state and `pdm_out` change only on strobe edges.
- R2: On each strobe with the tone enabled, the selected 16-bit frequency word is added to the 16-bit phase accumulator, modulo 2^16. A carry out of bit 15 causes exactly one oscillator step.
- R3: On an oscillator step, the velocity becomes velocity+1 if the position's bit 7 is 1, and velocity-1 if it is 0. The position then becomes position plus the new velocity. Both values are 8 bits and wrap.
- R4: Synchronous active-high reset sets the position to 0xFC (-4), the velocity to 0xF8 (-8), both accumulators to 0 and `pdm_out` to 0. With the tone enabled, `tone_level` therefore reads 0x7C after reset.
- R5: With the tone enabled, `tone_level` equals position + 128, modulo 256. On each strobe, `tone_level` is added to an 8-bit modulator accumulator. `pdm_out` takes the carry of that addition at the same edge and holds it until the next strobe.
- R6: The frequency word depends on `mode_sel` and `data_bit`. A `data_bit` of 1 (mark) selects the first word listed and 0 (space) selects the second:
  - mode 0: 0x22B7 (1300 Hz) / 0x3815 (2100 Hz)
  - mode 1: 0x0A6A (390 Hz) / 0x0C04 (450 Hz)
  - mode 2: 0x21EA (1270 Hz) / 0x1C93 (1070 Hz)
  - mode 3: 0x3B6B (2225 Hz) / 0x3614 (2025 Hz)
- R7: A change of `data_bit` or `mode_sel` takes effect at the next strobe. It does not clear the phase accumulator, the position or the velocity.
- R8: While `tone_en` is 0, `tone_level` reads 128 and the phase accumulator, position and velocity hold their values. The modulator keeps running on the level 128. When the tone is re-enabled, `tone_level` resumes from the held position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_en | input | 1 | 1 runs the tone; 0 parks the output at mid-scale and freezes the oscillator |
| data_bit | input | 1 | Serial data: 1 selects the mark word, 0 selects the space word |
| mode_sel | input | 2 | Channel plan select, encoded as in R6 |
| tone_level | output | 8 | Unsigned level fed to the modulator |
| pdm_out | output | 1 | Single-bit pulse-density output |

## Verification
The hardest situation to reach is a data or mode change that lands between oscillator steps. The phase accumulator then holds a partial sum, and a wrong restart would only show up strobes later as a shifted step time. The low 390/450 Hz plan gives about two dozen strobes per step, so the stimulus toggles `data_bit` and switches plans at irregular cycle counts. It also drops and restores `tone_en` in mid-tone. A strobe-by-strobe model then compares every cycle of `tone_level` and `pdm_out`, so a lost partial phase appears as a mismatch at the very next step.

// File: rtl/fsk_pdm_pkg.sv
package fsk_pdm_pkg;

    localparam int PHASE_W = 16;
    localparam int AMP_W   = 8;

    typedef enum logic [1:0] {
        PLAN_1300_2100 = 2'd0,
        PLAN_390_450   = 2'd1,
        PLAN_1270_1070 = 2'd2,
        PLAN_2225_2025 = 2'd3
    } plan_e;

    typedef struct packed {
        logic [AMP_W-1:0] pos;
        logic [AMP_W-1:0] vel;
    } osc_t;

    localparam logic [AMP_W-1:0] POS_INIT = AMP_W'(-4);
    localparam logic [AMP_W-1:0] VEL_INIT = AMP_W'(-8);
    localparam logic [AMP_W-1:0] MID_LVL  = AMP_W'(1 << (AMP_W - 1));

    function automatic logic [PHASE_W-1:0] freq_word(plan_e plan, logic mark);
        logic [PHASE_W-1:0] w;
        case (plan)
            PLAN_1300_2100: w = mark ? 16'h22B7 : 16'h3815;
            PLAN_390_450:   w = mark ? 16'h0A6A : 16'h0C04;
            PLAN_1270_1070: w = mark ? 16'h21EA : 16'h1C93;
            default:        w = mark ? 16'h3B6B : 16'h3614;
        endcase
        return w;
    endfunction

    function automatic logic [AMP_W-1:0] bias_level(logic en, logic [AMP_W-1:0] pos);
        return en ? AMP_W'(pos + MID_LVL) : MID_LVL;
    endfunction

endpackage

// File: rtl/fsk_strobe_div.sv
module fsk_strobe_div #(
    parameter int DIV = 163
) (
    input  logic clk,
    input  logic rst,
    output logic stb
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign stb = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (stb) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_chk
            // R1: strobes never come on two cycles in a row
            a_r1_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
                stb |=> !stb);
        end
    endgenerate

endmodule

// File: rtl/fsk_phase_osc.sv
module fsk_phase_osc
    import fsk_pdm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               advance,
    input  logic [PHASE_W-1:0] word,
    output logic [AMP_W-1:0]   pos
);
    logic [PHASE_W-1:0] phase;
    logic [PHASE_W:0]   phase_sum;
    logic               step;
    osc_t               st;
    osc_t               st_next;

    assign phase_sum = {1'b0, phase} + {1'b0, word};
    assign step      = advance && phase_sum[PHASE_W];

    always_comb begin
        st_next = st;
        st_next.vel = st.pos[AMP_W-1] ? AMP_W'(st.vel + 1'b1) : AMP_W'(st.vel - 1'b1);
        st_next.pos = AMP_W'(st.pos + st_next.vel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            st.pos <= POS_INIT;
            st.vel <= VEL_INIT;
        end else if (advance) begin
            phase <= phase_sum[PHASE_W-1:0];
            if (step) st <= st_next;
        end
    end

    assign pos = st.pos;

    // R3: a step moves the velocity by exactly one
    a_r3_vel_unit: assert property (@(posedge clk) disable iff (rst)
        step |=> ((st.vel == AMP_W'($past(st.vel) + 1'b1)) ||
                  (st.vel == AMP_W'($past(st.vel) - 1'b1))));
    // R3: new position is old position plus new velocity
    a_r3_pos_sum: assert property (@(posedge clk) disable iff (rst)
        step |=> (st.pos == AMP_W'($past(st.pos) + st.vel)));
    // R8: no advance, no change of oscillator state
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(phase) && $stable(st)));

endmodule

// File: rtl/fsk_pdm_mod.sv
module fsk_pdm_mod #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic [W-1:0] level,
    output logic         pdm_out
);
    logic [W-1:0] acc;
    logic [W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, level};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            pdm_out <= 1'b0;
        end else if (stb) begin
            acc     <= sum[W-1:0];
            pdm_out <= sum[W];
        end
    end

    // R5: output only moves on strobe edges
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(pdm_out));
    // R5: a full-scale level of zero never yields a pulse
    a_r5_zero_level: assert property (@(posedge clk) disable iff (rst)
        (stb && level == '0) |=> !pdm_out);

endmodule

// File: rtl/fsk_pdm_gen.sv
module fsk_pdm_gen
    import fsk_pdm_pkg::*;
#(
    parameter int STROBE_DIV = 163
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tone_en,
    input  logic       data_bit,
    input  logic [1:0] mode_sel,
    output logic [7:0] tone_level,
    output logic       pdm_out
);
    logic               stb;
    logic [PHASE_W-1:0] word;
    logic [AMP_W-1:0]   pos;

    fsk_strobe_div #(.DIV(STROBE_DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .stb (stb)
    );

    assign word = freq_word(plan_e'(mode_sel), data_bit);

    fsk_phase_osc u_osc (
        .clk     (clk),
        .rst     (rst),
        .advance (stb && tone_en),
        .word    (word),
        .pos     (pos)
    );

    assign tone_level = bias_level(tone_en, pos);

    fsk_pdm_mod #(.W(AMP_W)) u_mod (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .level   (tone_level),
        .pdm_out (pdm_out)
    );

    // R8: with the tone off the level is mid-scale
    a_r8_midscale: assert property (@(posedge clk) disable iff (rst)
        !tone_en |-> (tone_level == 8'd128));

endmodule

// File: tb/fsk_pdm_gen_bench.sv
module fsk_pdm_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tone_en = 1'b1;
    logic       data_bit = 1'b1;
    logic [1:0] mode_sel = 2'd0;
    logic [7:0] tone_level;
    logic       pdm_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic       pdm;
        logic [7:0] pos;
    } exp_t;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_pdm_gen #(.STROBE_DIV(DIV)) u_fsk_pdm_gen (
        .clk(clk), .rst(rst), .tone_en(tone_en), .data_bit(data_bit),
        .mode_sel(mode_sel), .tone_level(tone_level), .pdm_out(pdm_out)
    );

    function automatic logic [15:0] word_of(logic [1:0] m, logic d);
        case (m)
            2'd0: return d ? 16'h22B7 : 16'h3815;
            2'd1: return d ? 16'h0A6A : 16'h0C04;
            2'd2: return d ? 16'h21EA : 16'h1C93;
            default: return d ? 16'h3B6B : 16'h3614;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model: state after each rising edge, pushed at the negedge before it
    int         m_cnt = 0;
    logic [15:0] m_ph = '0;
    logic [7:0]  m_pos = 8'hFC, m_vel = 8'hF8, m_acc = '0;
    logic        m_pdm = 1'b0;

    always @(negedge clk) begin
        logic [8:0]  s;
        logic [16:0] p;
        logic [7:0]  lvl;
        if (rst) begin
            m_cnt = 0; m_ph = '0; m_pos = 8'hFC; m_vel = 8'hF8; m_acc = '0; m_pdm = 1'b0;
        end else if (m_cnt == DIV - 1) begin
            m_cnt = 0;
            lvl = tone_en ? 8'(m_pos + 8'd128) : 8'd128;
            s = {1'b0, m_acc} + {1'b0, lvl};
            m_acc = s[7:0];
            m_pdm = s[8];
            if (tone_en) begin
                p = {1'b0, m_ph} + {1'b0, word_of(mode_sel, data_bit)};
                m_ph = p[15:0];
                if (p[16]) begin
                    m_vel = m_pos[7] ? 8'(m_vel + 8'd1) : 8'(m_vel - 8'd1);
                    m_pos = 8'(m_pos + m_vel);
                end
            end
        end else begin
            m_cnt = m_cnt + 1;
        end
        sbq.push_back('{pdm: m_pdm, pos: m_pos});
    end

    // Monitor: compares the design with the item for the edge just past
    always @(negedge clk) begin
        #1;
        if (sbq.size() > 1 && !done) begin
            exp_t e;
            e = sbq.pop_front();
            check("R1 R2 R3 R5 R6 R7 pdm_out", {31'd0, pdm_out}, {31'd0, e.pdm});
            check("R3 R5 R8 tone_level", {24'd0, tone_level},
                  {24'd0, (tone_en ? 8'(e.pos + 8'd128) : 8'd128)});
        end
    end

    task automatic drive(logic en, logic d, logic [1:0] m, int cycles);
        @(posedge clk); #1;
        tone_en = en; data_bit = d; mode_sel = m;
        repeat (cycles) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 reset tone_level", {24'd0, tone_level}, 32'h7C);
        check("R4 reset pdm_out", {31'd0, pdm_out}, 32'd0);
        @(posedge clk); #1; rst = 1'b0;
        // R1: no change before the first strobe edge
        repeat (DIV - 1) @(posedge clk);
        #2; check("R1 pdm before strobe", {31'd0, pdm_out}, 32'd0);
        drive(1, 0, 2'd0, 3000);
        drive(1, 1, 2'd0, 2777);
        drive(1, 0, 2'd1, 4001);
        drive(1, 1, 2'd1, 3333);
        drive(1, 0, 2'd1, 517);
        drive(1, 1, 2'd2, 3003);
        drive(1, 0, 2'd2, 2999);
        drive(1, 1, 2'd3, 3101);
        drive(1, 0, 2'd3, 2903);
        // R8: freeze and resume
        @(negedge clk); held = tone_level;
        drive(0, 1, 2'd0, 2000);
        #2; check("R8 disabled level", {24'd0, tone_level}, 32'd128);
        drive(1, 0, 2'd3, 0);
        #2; check("R8 resume held level", {24'd0, tone_level}, {24'd0, held});
        drive(1, 1, 2'd1, 1777);
        drive(1, 0, 2'd1, 13);
        drive(1, 1, 2'd1, 29);
        drive(1, 0, 2'd0, 2500);
        // R4: reset mid-tone restores the initial state
        @(posedge clk); #1; rst = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check("R4 reset again level", {24'd0, tone_level}, 32'h7C);
        check("R4 reset again pdm", {31'd0, pdm_out}, 32'd0);
        @(posedge clk); #1; rst = 1'b0;
        repeat (3000) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule